// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter Chain

This block is the timekeeping core of a real-time clock. It holds the time and date as a bank of 4-bit BCD nibbles: tenths of seconds, seconds, minutes, hours, day of month, month, year and day of week. A separate setting register holds the hour-mode select, the AM/PM flag and a two-bit count of years since the last leap year. A single-cycle `tick` input, produced elsewhere at 10 Hz, advances the whole chain. All carries are resolved in one cycle, so every field that changes does so on the same clock edge.

A host reaches every register through a nibble-wide port with a 4-bit address. Writes are synchronous. Reads are combinational from `addr`. A stop bit in the control nibble freezes counting and clears the tenths digit. This lets software load a full time and then release the clock on a whole-second boundary. The day-of-month limit comes from the month registers and the leap counter. The day of week is a free 1-to-7 counter that advances at midnight.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the clock is stopped, the time reads 00:00:00.0 in 24-hour mode, the date reads day 01, month 01, year 00, the day of week reads 1, and the setting register reads 4'b0001.
- R2: While running, each `tick` advances tenths from 0 to 9 and wraps to 0, and the wrap carries into seconds. With `tick` low and no write, no register changes.
- R3: Address 0 is control, and its bit 2 is the stop bit. While it is 1, the tenths register holds 0 and no counter advances. Writing 0 resumes counting from a whole second. Reading address 0 returns the stop bit at bit 2 and 0 elsewhere.
- R4: Seconds (units at 2, tens at 3) and minutes (units at 4, tens at 5) count 00 to 59. Each wraps to 00 and carries to the next field.
- R5: In 24-hour mode, hours (units at 6, tens at 7) count 00 to 23. Rolling over from 23 to 00 advances the day.
- R6: In 12-hour mode, hours count 01 to 12, and 12 is followed by 01. Going from 11 to 12 toggles AM/PM. The day advances only on the 11:59:59.9 PM to 12:00:00.0 AM rollover.
- R7: Address F is the setting register. Bit 0 selects the mode (1 = 24-hour). Bit 1 is PM (0 = AM). Bits 3:2 are the leap counter. PM reads 0 in 24-hour mode.
- R8: Days (units at 8, tens at 9) count from 01. The month length is 30 for months 04, 06, 09 and 11. February has 29 days when the leap counter is 0 and 28 otherwise. All other months have 31.
- R9: Months (units at A, tens at B) count 01 to 12. The rollover from Dec 31 to Jan 1 advances the years (units at C, tens at D) from 99 to 00, and increments the leap counter, which wraps from 3 to 0.
- R10: The day of week (address E) advances at each day rollover, counting 1 to 7 and back to 1.
- R11: Unimplemented bits read 0, and writes to them are ignored. The tens widths are: seconds and minutes 3 bits, hours 2 bits in 24-hour mode and 1 bit in 12-hour mode, days 2 bits, months 1 bit, day of week 3 bits. Address 1 (tenths) ignores writes.
- R12: A host write to a register in the same cycle as a `tick` that would change it leaves the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 10 Hz advance enable |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Register address for reads and writes |
| wr_data | input | 4 | Write data nibble |
| rd_data | output | 4 | Read data of the addressed register |

## Verification
The assertions assume that `tick` is a single-cycle enable. They also assume that a host write lands on a clock edge like any other input. Registers are expected to start from reset or from legal BCD values, so the tenths range check relies only on writes to address 1 being dropped. The stimulus drives every input on the falling edge and loads complete legal times while the clock is stopped. It then releases the stop bit and applies exactly ten ticks to cross each rollover of interest.

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [3:0] wr_data,
  output logic [3:0] rd_data
);
  localparam logic [3:0] A_CTRL = 4'h0, A_TNTH = 4'h1, A_SECU = 4'h2, A_SECT = 4'h3;
  localparam logic [3:0] A_MINU = 4'h4, A_MINT = 4'h5, A_HRU  = 4'h6, A_HRT  = 4'h7;
  localparam logic [3:0] A_DAYU = 4'h8, A_DAYT = 4'h9, A_MONU = 4'hA, A_MONT = 4'hB;
  localparam logic [3:0] A_YRU  = 4'hC, A_YRT  = 4'hD, A_DOW  = 4'hE, A_SET  = 4'hF;

  logic       stop, h24, pm, mont;
  logic [1:0] leap, hrt, dayt;
  logic [2:0] sect, mint, dow;
  logic [3:0] tth, secu, minu, hru, dayu, monu, yru, yrt;

  logic       n_stop, n_h24, n_pm, n_mont;
  logic [1:0] n_leap, n_hrt, n_dayt;
  logic [2:0] n_sect, n_mint, n_dow;
  logic [3:0] n_tth, n_secu, n_minu, n_hru, n_dayu, n_monu, n_yru, n_yrt;

  logic       run, c_sec, c_min, c_hr, c_day, c_mon, c_yr;
  logic       is_feb, is_short, day_last;
  logic [1:0] lim_t;
  logic [3:0] lim_u;

  assign is_feb   = !mont && monu == 4'd2;
  assign is_short = (!mont && (monu == 4'd4 || monu == 4'd6 || monu == 4'd9)) ||
                    (mont && monu == 4'd1);
  assign lim_t    = is_feb ? 2'd2 : 2'd3;
  assign lim_u    = is_feb ? ((leap == 2'd0) ? 4'd9 : 4'd8) : (is_short ? 4'd0 : 4'd1);
  assign day_last = dayt == lim_t && dayu == lim_u;

  assign run   = tick && !stop;
  assign c_sec = run && tth == 4'd9;
  assign c_min = c_sec && secu == 4'd9 && sect == 3'd5;
  assign c_hr  = c_min && minu == 4'd9 && mint == 3'd5;
  assign c_day = c_hr && (h24 ? (hrt == 2'd2 && hru == 4'd3)
                              : (pm && hrt == 2'd1 && hru == 4'd1));
  assign c_mon = c_day && day_last;
  assign c_yr  = c_mon && mont && monu == 4'd2;

  always_comb begin
    n_stop = stop; n_h24 = h24; n_pm = pm; n_leap = leap;
    n_tth = tth; n_secu = secu; n_sect = sect; n_minu = minu; n_mint = mint;
    n_hru = hru; n_hrt = hrt; n_dayu = dayu; n_dayt = dayt;
    n_monu = monu; n_mont = mont; n_yru = yru; n_yrt = yrt; n_dow = dow;

    if (run) n_tth = (tth == 4'd9) ? 4'd0 : tth + 4'd1;
    if (c_sec) begin
      n_secu = (secu == 4'd9) ? 4'd0 : secu + 4'd1;
      if (secu == 4'd9) n_sect = (sect == 3'd5) ? 3'd0 : sect + 3'd1;
    end
    if (c_min) begin
      n_minu = (minu == 4'd9) ? 4'd0 : minu + 4'd1;
      if (minu == 4'd9) n_mint = (mint == 3'd5) ? 3'd0 : mint + 3'd1;
    end
    if (c_hr) begin
      if (h24) begin
        if (hrt == 2'd2 && hru == 4'd3) begin n_hrt = 2'd0; n_hru = 4'd0; end
        else if (hru == 4'd9) begin n_hrt = hrt + 2'd1; n_hru = 4'd0; end
        else n_hru = hru + 4'd1;
      end else begin
        if (hrt == 2'd1 && hru == 4'd2) begin n_hrt = 2'd0; n_hru = 4'd1; end
        else if (hrt == 2'd1 && hru == 4'd1) begin n_hru = 4'd2; n_pm = !pm; end
        else if (hru == 4'd9) begin n_hrt = 2'd1; n_hru = 4'd0; end
        else n_hru = hru + 4'd1;
      end
    end
    if (c_day) begin
      n_dow = (dow == 3'd7) ? 3'd1 : dow + 3'd1;
      if (day_last) begin n_dayt = 2'd0; n_dayu = 4'd1; end
      else if (dayu == 4'd9) begin n_dayt = dayt + 2'd1; n_dayu = 4'd0; end
      else n_dayu = dayu + 4'd1;
    end
    if (c_mon) begin
      if (mont && monu == 4'd2) begin n_mont = 1'b0; n_monu = 4'd1; end
      else if (monu == 4'd9) begin n_mont = 1'b1; n_monu = 4'd0; end
      else n_monu = monu + 4'd1;
    end
    if (c_yr) begin
      n_leap = leap + 2'd1;
      if (yru == 4'd9) begin
        n_yru = 4'd0;
        n_yrt = (yrt == 4'd9) ? 4'd0 : yrt + 4'd1;
      end else n_yru = yru + 4'd1;
    end

    if (wr_en) begin
      case (addr)
        A_CTRL: begin n_stop = wr_data[2]; if (wr_data[2]) n_tth = 4'd0; end
        A_SECU: n_secu = wr_data;
        A_SECT: n_sect = wr_data[2:0];
        A_MINU: n_minu = wr_data;
        A_MINT: n_mint = wr_data[2:0];
        A_HRU:  n_hru  = wr_data;
        A_HRT:  n_hrt  = h24 ? wr_data[1:0] : {1'b0, wr_data[0]};
        A_DAYU: n_dayu = wr_data;
        A_DAYT: n_dayt = wr_data[1:0];
        A_MONU: n_monu = wr_data;
        A_MONT: n_mont = wr_data[0];
        A_YRU:  n_yru  = wr_data;
        A_YRT:  n_yrt  = wr_data;
        A_DOW:  n_dow  = wr_data[2:0];
        A_SET:  begin n_leap = wr_data[3:2]; n_h24 = wr_data[0]; n_pm = wr_data[1] && !wr_data[0]; end
        default: ;
      endcase
    end
    if (n_stop) n_tth = 4'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop <= 1'b1; h24 <= 1'b1; pm <= 1'b0; leap <= 2'd0;
      tth <= 4'd0; secu <= 4'd0; sect <= 3'd0; minu <= 4'd0; mint <= 3'd0;
      hru <= 4'd0; hrt <= 2'd0; dayu <= 4'd1; dayt <= 2'd0;
      monu <= 4'd1; mont <= 1'b0; yru <= 4'd0; yrt <= 4'd0; dow <= 3'd1;
    end else begin
      stop <= n_stop; h24 <= n_h24; pm <= n_pm; leap <= n_leap;
      tth <= n_tth; secu <= n_secu; sect <= n_sect; minu <= n_minu; mint <= n_mint;
      hru <= n_hru; hrt <= n_hrt; dayu <= n_dayu; dayt <= n_dayt;
      monu <= n_monu; mont <= n_mont; yru <= n_yru; yrt <= n_yrt; dow <= n_dow;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL: rd_data = {1'b0, stop, 2'b00};
      A_TNTH: rd_data = tth;
      A_SECU: rd_data = secu;
      A_SECT: rd_data = {1'b0, sect};
      A_MINU: rd_data = minu;
      A_MINT: rd_data = {1'b0, mint};
      A_HRU:  rd_data = hru;
      A_HRT:  rd_data = {2'b00, hrt & (h24 ? 2'b11 : 2'b01)};
      A_DAYU: rd_data = dayu;
      A_DAYT: rd_data = {2'b00, dayt};
      A_MONU: rd_data = monu;
      A_MONT: rd_data = {3'b000, mont};
      A_YRU:  rd_data = yru;
      A_YRT:  rd_data = yrt;
      A_DOW:  rd_data = {1'b0, dow};
      default: rd_data = {leap, pm, h24};
    endcase
  end

  assert_tenths_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tth <= 4'd9);
  assert_tenths_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !(wr_en && addr == A_CTRL) && tth != 4'd9) |=> tth == $past(tth) + 4'd1);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable({stop, h24, pm, leap, tth, secu, sect, minu, mint,
                                   hru, hrt, dayu, dayt, monu, mont, yru, yrt, dow}));
  assert_stop_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> tth == 4'd0);
  assert_pm_24h_R7: assert property (@(posedge clk) disable iff (!rst_n)
    h24 |-> !pm);
endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'h0, wr_data = 4'h0;
  logic [3:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_calendar_core u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                           .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [3:0] e, input string tag);
    logic [3:0] v;
    @(negedge clk); addr = a; #1 v = rd_data;
    checks++;
    if (v !== e) begin
      errors++;
      $display("FAIL %s addr %h: got %h expected %h", tag, a, v, e);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_hms(input logic [3:0] ht, hu, mt, mu, st, su);
    wr(4'h0, 4'h4);
    wr(4'h7, ht); wr(4'h6, hu); wr(4'h5, mt); wr(4'h4, mu); wr(4'h3, st); wr(4'h2, su);
  endtask

  task automatic midnight(input logic [3:0] mot, mou, dt, du);
    set_hms(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
    wr(4'hB, mot); wr(4'hA, mou); wr(4'h9, dt); wr(4'h8, du);
    wr(4'h0, 4'h0);
    ticks(10);
  endtask

  task automatic t_reset;
    expect_reg(4'h0, 4'h4, "R1");
    expect_reg(4'hF, 4'h1, "R1");
    expect_reg(4'h1, 4'h0, "R1");
    expect_reg(4'h7, 4'h0, "R1");
    expect_reg(4'h8, 4'h1, "R1");
    expect_reg(4'hA, 4'h1, "R1");
    expect_reg(4'hE, 4'h1, "R1");
  endtask

  task automatic t_tenths_stop;
    wr(4'h0, 4'h0);
    ticks(3);
    expect_reg(4'h1, 4'h3, "R2");
    repeat (5) @(negedge clk);
    expect_reg(4'h1, 4'h3, "R2 idle");
    wr(4'h0, 4'h4);
    expect_reg(4'h1, 4'h0, "R3");
    ticks(5);
    expect_reg(4'h1, 4'h0, "R3 stopped");
    expect_reg(4'h2, 4'h0, "R3 stopped");
    wr(4'h0, 4'h0);
    ticks(10);
    expect_reg(4'h1, 4'h0, "R3 resume");
    expect_reg(4'h2, 4'h1, "R2 carry");
  endtask

  task automatic t_24h;
    wr(4'hE, 4'h7);
    midnight(4'd0, 4'd6, 4'd1, 4'd5);
    expect_reg(4'h2, 4'h0, "R4");
    expect_reg(4'h3, 4'h0, "R4");
    expect_reg(4'h4, 4'h0, "R4");
    expect_reg(4'h5, 4'h0, "R4");
    expect_reg(4'h6, 4'h0, "R5");
    expect_reg(4'h7, 4'h0, "R5");
    expect_reg(4'h8, 4'h6, "R5 day");
    expect_reg(4'hE, 4'h1, "R10 wrap");
  endtask

  task automatic t_12h;
    wr(4'h0, 4'h4);
    wr(4'hF, 4'h0);
    set_hms(4'd1, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9);
    wr(4'hF, 4'h2);
    expect_reg(4'hF, 4'h2, "R7 pm");
    wr(4'h0, 4'h0);
    ticks(10);
    expect_reg(4'h6, 4'h2, "R6 midnight");
    expect_reg(4'h7, 4'h1, "R6 midnight");
    expect_reg(4'hF, 4'h0, "R6 am");
    expect_reg(4'h8, 4'h7, "R6 day");
    expect_reg(4'hE, 4'h2, "R10");
    set_hms(4'd1, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9);
    wr(4'h0, 4'h0);
    ticks(10);
    expect_reg(4'h6, 4'h2, "R6 noon");
    expect_reg(4'hF, 4'h2, "R6 pm");
    expect_reg(4'h8, 4'h7, "R6 no day");
    set_hms(4'd1, 4'd2, 4'd5, 4'd9, 4'd5, 4'd9);
    wr(4'h0, 4'h0);
    ticks(10);
    expect_reg(4'h6, 4'h1, "R6 one");
    expect_reg(4'h7, 4'h0, "R6 one");
    expect_reg(4'hF, 4'h2, "R6 one");
    wr(4'h7, 4'hF);
    expect_reg(4'h7, 4'h1, "R11 12h tens");
  endtask

  task automatic t_months;
    wr(4'h0, 4'h4);
    wr(4'hF, 4'h1);
    expect_reg(4'hF, 4'h1, "R7 24h");
    midnight(4'd0, 4'd2, 4'd2, 4'd8);
    expect_reg(4'h8, 4'h9, "R8 leap 29");
    expect_reg(4'hA, 4'h2, "R8 leap 29");
    midnight(4'd0, 4'd2, 4'd2, 4'd9);
    expect_reg(4'h8, 4'h1, "R8 leap mar");
    expect_reg(4'hA, 4'h3, "R8 leap mar");
    wr(4'hF, 4'h5);
    midnight(4'd0, 4'd2, 4'd2, 4'd8);
    expect_reg(4'h8, 4'h1, "R8 common");
    expect_reg(4'h9, 4'h0, "R8 common");
    expect_reg(4'hA, 4'h3, "R8 common");
    midnight(4'd0, 4'd4, 4'd3, 4'd0);
    expect_reg(4'h8, 4'h1, "R8 april");
    expect_reg(4'hA, 4'h5, "R8 april");
    midnight(4'd0, 4'd1, 4'd3, 4'd0);
    expect_reg(4'h8, 4'h1, "R8 jan 30");
    expect_reg(4'h9, 4'h3, "R8 jan 30");
  endtask

  task automatic t_year;
    wr(4'h0, 4'h4);
    wr(4'hF, 4'hD);
    wr(4'hC, 4'h9); wr(4'hD, 4'h9);
    midnight(4'd1, 4'd2, 4'd3, 4'd1);
    expect_reg(4'hA, 4'h1, "R9");
    expect_reg(4'hB, 4'h0, "R9");
    expect_reg(4'h8, 4'h1, "R9");
    expect_reg(4'hC, 4'h0, "R9 wrap");
    expect_reg(4'hD, 4'h0, "R9 wrap");
    expect_reg(4'hF, 4'h1, "R9 leap wrap");
    wr(4'h0, 4'h4);
    wr(4'hF, 4'h5);
    wr(4'hC, 4'h9); wr(4'hD, 4'h1);
    midnight(4'd1, 4'd2, 4'd3, 4'd1);
    expect_reg(4'hC, 4'h0, "R9");
    expect_reg(4'hD, 4'h2, "R9");
    expect_reg(4'hF, 4'h9, "R9 leap");
  endtask

  task automatic t_masks;
    wr(4'h0, 4'h0);
    ticks(3);
    wr(4'h1, 4'h9);
    expect_reg(4'h1, 4'h3, "R11 ro");
    wr(4'h0, 4'h4);
    wr(4'h3, 4'hD);
    expect_reg(4'h3, 4'h5, "R11");
    wr(4'hB, 4'hE);
    expect_reg(4'hB, 4'h0, "R11");
    wr(4'hE, 4'hF);
    expect_reg(4'hE, 4'h7, "R11");
    wr(4'h9, 4'hF);
    expect_reg(4'h9, 4'h3, "R11");
    wr(4'h0, 4'hB);
    expect_reg(4'h0, 4'h0, "R3 read");
  endtask

  task automatic t_priority;
    wr(4'h0, 4'h4);
    wr(4'h2, 4'h9); wr(4'h3, 4'h0);
    wr(4'h0, 4'h0);
    ticks(9);
    expect_reg(4'h1, 4'h9, "R12 setup");
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 4'h2; wr_data = 4'h4;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    expect_reg(4'h2, 4'h4, "R12");
    expect_reg(4'h1, 4'h0, "R12");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_tenths_stop;
    t_24h;
    t_12h;
    t_months;
    t_year;
    t_masks;
    t_priority;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule